// File: doc/BRIEF.md
# Synchronous Receive Character Filter with CRC-16

This block sits between the byte assembler of a synchronous serial receiver and its receive FIFO. Each assembled character arrives on a valid/ready input. The block decides, in the same cycle, whether that character is written to the FIFO. A character is dropped when the receiver is disabled. It is also dropped when load-inhibit is on and the character equals a programmable sync byte. Dropped characters raise no receive interrupt.

In byte-synchronous mode the block also runs a CRC-16 over the received stream. The CRC-enable input is sampled at the moment each character is transferred, and that sampled value is stored with the character. The character then waits one character time in a delay stage. It is folded into the CRC only when the next character is transferred. The delay gives the controller a full character time to decide whether the previous character belongs in the check. A character dropped as a sync byte still enters the CRC if its sampled enable was set. In asynchronous mode the CRC is frozen. Clearing the receiver enable presets the CRC and empties the delay stage, which returns the receiver to hunt.

The output stream follows valid/ready rules:
- A character to be written holds the input (in_ready low) until the FIFO side accepts it.
- A dropped character is always consumed at once.
- in_ready does not depend on in_valid.

Top module: `sync_rx_char_filter`

## Requirements
- R1: While reset is active and on the first cycle after it, out_valid and rx_irq are 0, crc_value is 16'hFFFF and crc_ok is 0.
- R2: With rx_en high, an input character that is not dropped appears on out_valid/out_data in the same cycle, unchanged, and in_ready equals out_ready.
- R3: With inhibit_en high, a character equal to sync_byte is consumed (in_ready high) without a write (out_valid low), in both sync and async mode.
- R4: rx_irq is a one-cycle pulse in the cycle after each completed FIFO write (out_valid and out_ready both high), and is low otherwise.
- R5: In sync mode (async_mode = 0), an accepted character whose sampled crc_en was high is folded into crc_value on the clock edge that accepts the next character, not on its own edge. crc_value changes only on edges that accept a character or clear the CRC.
- R6: crc_en is sampled when the character is transferred. A character transferred with crc_en low never enters the CRC, even if crc_en rises before it would be folded.
- R7: A sync character dropped by load-inhibit enters the CRC like any other character when its sampled crc_en is high.
- R8: In async mode (async_mode = 1), accepted characters neither change crc_value nor enter the delay stage.
- R9: While rx_en is low, input characters are consumed with no write. On the following edge crc_value becomes 16'hFFFF and the delay stage is emptied.
- R10: The CRC uses polynomial x^16+x^12+x^5+1, preset 16'hFFFF, processed LSB first (reflected constant 16'h8408) with no final inversion. crc_ok is high exactly when crc_value equals the good residue 16'hF0B8. This residue is reached after a frame followed by its complemented CRC, low byte first, has been folded.
- R11: When a character to be written meets out_ready low, in_ready is low, and neither the CRC, the delay stage nor rx_irq changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Assembled character present |
| in_ready | output | 1 | Character taken this cycle when in_valid is high |
| in_data | input | 8 | Assembled character |
| rx_en | input | 1 | Receiver enable; low clears CRC and delay stage |
| crc_en | input | 1 | CRC inclusion for the character being transferred |
| inhibit_en | input | 1 | Drop characters that equal sync_byte |
| sync_byte | input | 8 | Programmed sync character |
| async_mode | input | 1 | 1 = asynchronous (CRC frozen), 0 = byte-synchronous |
| out_valid | output | 1 | FIFO write request |
| out_ready | input | 1 | FIFO can accept a character |
| out_data | output | 8 | Character to write |
| rx_irq | output | 1 | Receive interrupt pulse after each write |
| crc_value | output | 16 | Running CRC register |
| crc_ok | output | 1 | CRC register equals the good residue |

## Verification
The bench aims at the one-character CRC delay. A design that folded each byte on its own edge would show a CRC value one character early. The bench also toggles crc_en between a transfer and the following fold. A design that read the enable late would include a byte the controller meant to exclude.

Inhibited sync bytes are checked for a missing write together with a CRC step on the next transfer. Getting either wrong would corrupt the stream or the check. Back-pressure stalls, async periods and receiver-enable drops are mixed into long random runs against a reference model. These runs catch any CRC motion on a stalled or dropped character, and any residue left over after a disable.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic {
    MODE_SYNC  = 1'b0,
    MODE_ASYNC = 1'b1
  } rx_mode_e;

endpackage

// File: rtl/rxf_char_filter.sv
module rxf_char_filter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              rx_en,
  input  logic              inhibit_en,
  input  logic [DATA_W-1:0] sync_byte,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              accept,
  output logic              write_done
);

  logic is_sync;
  logic drop;

  assign is_sync    = (in_data == sync_byte);
  assign drop       = !rx_en || (inhibit_en && is_sync);
  assign out_valid  = in_valid && !drop;
  assign out_data   = in_data;
  assign in_ready   = drop || out_ready;
  assign accept     = in_valid && in_ready;
  assign write_done = out_valid && out_ready;

  // R3
  inhibit_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && inhibit_en && in_data == sync_byte) |-> (!out_valid && in_ready));

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9
  disabled_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> (!out_valid && in_ready));

endmodule

// File: rtl/rxf_crc_delay.sv
module rxf_crc_delay #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  input  logic [DATA_W-1:0] new_data,
  input  logic              new_incl,
  output logic              fold,
  output logic [DATA_W-1:0] fold_data
);

  logic              held_vld;
  logic              held_incl;
  logic [DATA_W-1:0] held_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_vld  <= 1'b0;
      held_incl <= 1'b0;
      held_data <= '0;
    end else if (clear) begin
      held_vld  <= 1'b0;
      held_incl <= 1'b0;
    end else if (advance) begin
      held_vld  <= 1'b1;
      held_incl <= new_incl;
      held_data <= new_data;
    end
  end

  assign fold      = advance && !clear && held_vld && held_incl;
  assign fold_data = held_data;

  // R9
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !fold);

endmodule

// File: rtl/rxf_crc16.sv
module rxf_crc16 #(
  parameter int              DATA_W   = 8,
  parameter int              CRC_W    = 16,
  parameter logic [CRC_W-1:0] POLY_REF = 16'h8408,
  parameter logic [CRC_W-1:0] PRESET   = 16'hFFFF,
  parameter logic [CRC_W-1:0] GOOD     = 16'hF0B8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              fold,
  input  logic [DATA_W-1:0] fold_data,
  output logic [CRC_W-1:0]  crc_value,
  output logic              crc_ok
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_next;

  always_comb begin
    crc_next = crc_q ^ {{(CRC_W-DATA_W){1'b0}}, fold_data};
    for (int b = 0; b < DATA_W; b++) begin
      if (crc_next[0]) crc_next = (crc_next >> 1) ^ POLY_REF;
      else             crc_next = crc_next >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc_q <= PRESET;
    else if (clear) crc_q <= PRESET;
    else if (fold)  crc_q <= crc_next;
  end

  assign crc_value = crc_q;
  assign crc_ok    = (crc_q == GOOD);

  // R9
  clear_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (crc_value == PRESET));

  // R5
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fold && !clear) |=> $stable(crc_value));

endmodule

// File: rtl/sync_rx_char_filter.sv
module sync_rx_char_filter
  import rxf_pkg::*;
#(
  parameter int               DATA_W    = 8,
  parameter int               CRC_W     = 16,
  parameter logic [CRC_W-1:0] CRC_POLY  = 16'h8408,
  parameter logic [CRC_W-1:0] CRC_INIT  = 16'hFFFF,
  parameter logic [CRC_W-1:0] CRC_GOOD  = 16'hF0B8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              rx_en,
  input  logic              crc_en,
  input  logic              inhibit_en,
  input  logic [DATA_W-1:0] sync_byte,
  input  logic              async_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              rx_irq,
  output logic [CRC_W-1:0]  crc_value,
  output logic              crc_ok
);

  rx_mode_e          mode;
  logic              accept;
  logic              write_done;
  logic              advance;
  logic              clear;
  logic              fold;
  logic [DATA_W-1:0] fold_data;
  logic              irq_q;

  assign mode    = async_mode ? MODE_ASYNC : MODE_SYNC;
  assign clear   = !rx_en;
  assign advance = accept && (mode == MODE_SYNC);

  rxf_char_filter #(.DATA_W(DATA_W)) u_filter (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .rx_en      (rx_en),
    .inhibit_en (inhibit_en),
    .sync_byte  (sync_byte),
    .out_ready  (out_ready),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .accept     (accept),
    .write_done (write_done)
  );

  rxf_crc_delay #(.DATA_W(DATA_W)) u_delay (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .advance   (advance),
    .new_data  (in_data),
    .new_incl  (crc_en),
    .fold      (fold),
    .fold_data (fold_data)
  );

  rxf_crc16 #(
    .DATA_W   (DATA_W),
    .CRC_W    (CRC_W),
    .POLY_REF (CRC_POLY),
    .PRESET   (CRC_INIT),
    .GOOD     (CRC_GOOD)
  ) u_crc (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .fold      (fold),
    .fold_data (fold_data),
    .crc_value (crc_value),
    .crc_ok    (crc_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= write_done;
  end

  assign rx_irq = irq_q;

  // R4
  irq_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> rx_irq);

  // R4
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_ready) |=> !rx_irq);

  // R8
  async_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && async_mode) |=> $stable(crc_value));

  // R11
  stall_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && in_valid && !in_ready) |=> $stable(crc_value));

endmodule

// File: tb/sync_rx_char_filter_tb.sv
module sync_rx_char_filter_tb;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_data;
  logic        rx_en;
  logic        crc_en;
  logic        inhibit_en;
  logic [7:0]  sync_byte;
  logic        async_mode;
  logic        out_valid;
  logic        out_ready;
  logic [7:0]  out_data;
  logic        rx_irq;
  logic [15:0] crc_value;
  logic        crc_ok;

  int checks;
  int fails;

  // reference model state
  int        m_crc;
  bit [8:0]  m_q[$];
  bit        m_irq;

  sync_rx_char_filter u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .rx_en      (rx_en),
    .crc_en     (crc_en),
    .inhibit_en (inhibit_en),
    .sync_byte  (sync_byte),
    .async_mode (async_mode),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .rx_irq     (rx_irq),
    .crc_value  (crc_value),
    .crc_ok     (crc_ok)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int ref_crc(int c, int d);
    int r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (((r ^ (d >> i)) & 1) != 0) r = (r >> 1) ^ 'h8408;
      else r = r >> 1;
    end
    return r & 'hFFFF;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit m_drop();
    return !rx_en || (inhibit_en && in_data == sync_byte);
  endfunction

  task automatic step();
    bit wr;
    bit rdy;
    bit acc;
    bit [8:0] e;
    #8;
    wr  = in_valid && !m_drop();
    rdy = m_drop() || out_ready;
    acc = in_valid && rdy;
    chk(out_valid == wr, "R2/R3 out_valid", out_valid, wr);
    chk(in_ready == rdy, "R11 in_ready", in_ready, rdy);
    if (wr) chk(out_data == in_data, "R2 out_data", out_data, in_data);
    chk(rx_irq == m_irq, "R4 rx_irq", rx_irq, m_irq);
    chk(crc_value == m_crc[15:0], "R5 crc_value", crc_value, m_crc);
    chk(crc_ok == (m_crc == 'hF0B8), "R10 crc_ok", crc_ok, (m_crc == 'hF0B8));
    @(posedge clk);
    if (!rst_n) begin
      m_crc = 'hFFFF; m_q.delete(); m_irq = 0;
    end else if (!rx_en) begin
      m_crc = 'hFFFF; m_q.delete(); m_irq = 0;
    end else begin
      m_irq = wr && out_ready;
      if (acc && !async_mode) begin
        if (m_q.size() > 0) begin
          e = m_q.pop_front();
          if (e[8]) m_crc = ref_crc(m_crc, e[7:0]);
        end
        m_q.push_back({crc_en, in_data});
      end
    end
    #2;
  endtask

  task automatic send(input int d);
    in_valid = 1'b1; in_data = d[7:0];
    step();
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int c0;
    int c1;
    int fc;
    checks = 0; fails = 0;
    m_crc = 'hFFFF; m_irq = 0;
    rst_n = 0; in_valid = 0; in_data = 0; rx_en = 0; crc_en = 0;
    inhibit_en = 0; sync_byte = 8'h16; async_mode = 0; out_ready = 1;
    @(posedge clk); #2;
    chk(out_valid == 0 && rx_irq == 0, "R1 reset outputs", {out_valid, rx_irq}, 0);
    chk(crc_value == 16'hFFFF && !crc_ok, "R1 reset crc", crc_value, 'hFFFF);
    step(); step();
    rst_n = 1;
    step();
    chk(crc_value == 16'hFFFF && rx_irq == 0, "R1 after reset", crc_value, 'hFFFF);

    // directed: delay, sampling, inhibited sync
    rx_en = 1; crc_en = 1; inhibit_en = 1;
    send('hA5);
    chk(crc_value == 16'hFFFF, "R5 no fold on own edge", crc_value, 'hFFFF);
    c0 = ref_crc('hFFFF, 'hA5);
    in_valid = 1; in_data = 8'h16; #1;
    chk(!out_valid && in_ready, "R3 sync inhibited", {out_valid, in_ready}, 1);
    step();
    chk(crc_value == c0[15:0], "R5 fold on next edge", crc_value, c0);
    c1 = ref_crc(c0, 'h16);
    crc_en = 0;
    send('h3C);
    chk(crc_value == c1[15:0], "R7 inhibited sync in CRC", crc_value, c1);
    crc_en = 1;
    send('h77);
    chk(crc_value == c1[15:0], "R6 excluded byte", crc_value, c1);

    async_mode = 1;
    send('h55); send('h16); send('h99);
    chk(crc_value == c1[15:0], "R8 async frozen", crc_value, c1);
    async_mode = 0;

    // back-pressure
    out_ready = 0; in_valid = 1; in_data = 8'h42; #1;
    chk(!in_ready && out_valid, "R11 stall", {in_ready, out_valid}, 1);
    step();
    chk(rx_irq == 0, "R11 no irq on stall", rx_irq, 0);
    out_ready = 1;
    step();
    chk(rx_irq == 1, "R4 irq after write", rx_irq, 1);
    in_valid = 0;
    step();
    chk(rx_irq == 0, "R4 irq one pulse", rx_irq, 0);

    // disable
    rx_en = 0; in_valid = 1; in_data = 8'h11; #1;
    chk(!out_valid && in_ready, "R9 disabled consume", {out_valid, in_ready}, 1);
    step();
    chk(crc_value == 16'hFFFF, "R9 crc preset", crc_value, 'hFFFF);

    // random run
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      rx_en      = (r > 3);
      in_valid   = ($urandom_range(0, 3) != 0);
      in_data    = ($urandom_range(0, 4) == 0) ? sync_byte : 8'($urandom);
      crc_en     = ($urandom_range(0, 3) != 0);
      inhibit_en = ($urandom_range(0, 1) != 0);
      async_mode = ($urandom_range(0, 9) == 0);
      out_ready  = ($urandom_range(0, 3) != 0);
      if (n == 2000) sync_byte = 8'h7E;
      step();
    end

    // frame with good residue
    rx_en = 0; in_valid = 0; step();
    rx_en = 1; crc_en = 1; inhibit_en = 0; async_mode = 0; out_ready = 1;
    fc = 'hFFFF;
    for (int k = 0; k < 5; k++) begin
      fc = ref_crc(fc, k * 37 + 3);
      send(k * 37 + 3);
    end
    send((fc ^ 'hFFFF) & 'hFF);
    send(((fc ^ 'hFFFF) >> 8) & 'hFF);
    chk(!crc_ok, "R10 not yet folded", crc_ok, 0);
    send('h00);
    chk(crc_ok == 1 && crc_value == 16'hF0B8, "R10 good residue", crc_value, 'hF0B8);
    in_valid = 0;
    step();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule